// File: doc/BRIEF.md
# Trap and Status Flag Controller

This block owns the processor's 16-bit status word and decides, once per clock, whether the instruction stream is diverted into a trap. The low byte is the live flag set: four condition flags from the ALU plus an interrupt-mask bit. The high byte is a shadow copy that is filled on trap entry and read back on return. Requests come from outside the core (a reset request, a non-maskable request, a watch-address hit and a maskable request) and from decoded instructions (software reset, non-maskable and maskable traps, a system call, a break, mask set, mask clear, mask restore, return-from-trap and stop).

When a trap is accepted, the block pulses a take strobe for one cycle. It presents the fixed entry address for the winning cause and the program counter of the displaced instruction. It also says whether that address should be written to the return-address register. While a constant prefix is being consumed, external requests wait. A stop instruction stalls the core until an external release input is seen. That release does not cause a trap.

Top module: `trapFlagUnit`

## Requirements
- R1: After reset, statusOut is 0x0010: the mask bit (bit 4) is set, the condition flags (bits 3:0), bits 7:5 and the shadow byte (bits 15:8) are zero, and takeTrap, saveRet, pcRestore and stalled are low.
- R2: An accepted trap raises takeTrap in the cycle after the request is sampled. In that same cycle retAddr holds curPc from the sampled cycle, the shadow byte holds the previous live byte, and the live byte keeps its flags with the mask bit set.
- R3: The entry addresses are 0xFFFC for reset, 0xFFF8 for non-maskable, 0xFFF0 for watch hit, 0xFFF4 for maskable, 0xFFC4 for system call and 0xFFC0 for break. saveRet accompanies every take except one caused by the external reset request.
- R4: When several requests coincide, the winner follows this order: reset, non-maskable, watch, maskable, system call, break.
- R5: A maskable request, external or software, is ignored while the live mask bit is set. Non-maskable requests are taken regardless of the mask.
- R6: While prefixBusy is high, external non-maskable, watch and maskable requests are not accepted. Reset and software requests are still accepted.
- R7: External reset and non-maskable requests act on a rising edge and stay pending until taken. takeTrap is never high on two consecutive cycles, because no trap is accepted in the cycle after a take.
- R8: diOp sets the live mask bit and eiOp clears it, one cycle later. No other bit changes.
- R9: riOp copies only the shadow mask bit into the live mask bit. The flags and the shadow byte are unchanged.
- R10: iretOp copies the shadow byte into the live byte and pulses pcRestore for one cycle.
- R11: flagUpd loads flagNew into live bits 3:0 without touching the mask bit.
- R12: In a cycle where a trap is accepted, the instruction strobes of that cycle (flag load, mask set/clear/restore, return and stop) have no effect.
- R13: stopOp raises stalled from the next cycle. stalled falls in the cycle after go is sampled high, or when a trap is taken. go alone never causes a take.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hwResetReq | input | 1 | External reset request, rising-edge |
| nmiReq | input | 1 | External non-maskable request, rising-edge |
| watchReq | input | 1 | Watch-address hit, level |
| irqReq | input | 1 | External maskable request, level |
| prefixBusy | input | 1 | Constant prefix in progress; holds off external requests |
| swResetOp | input | 1 | Decoded software reset trap |
| swNmiOp | input | 1 | Decoded software non-maskable trap |
| swIrqOp | input | 1 | Decoded software maskable trap |
| sysOp | input | 1 | Decoded system call |
| brkOp | input | 1 | Decoded break |
| diOp | input | 1 | Decoded mask set |
| eiOp | input | 1 | Decoded mask clear |
| riOp | input | 1 | Decoded mask restore from shadow |
| iretOp | input | 1 | Decoded return from trap |
| stopOp | input | 1 | Decoded stop |
| go | input | 1 | External release of a stop stall |
| flagUpd | input | 1 | Load condition flags |
| flagNew | input | 4 | Condition flags from the ALU |
| curPc | input | 16 | PC of the instruction in this cycle |
| takeTrap | output | 1 | One-cycle trap entry strobe |
| trapVector | output | 16 | Entry address of the accepted trap |
| saveRet | output | 1 | Write retAddr to the return-address register |
| retAddr | output | 16 | PC of the displaced instruction |
| pcRestore | output | 1 | Return-from-trap accepted; reload PC from the saved address |
| stalled | output | 1 | Core held by stop |
| statusOut | output | 16 | Status word, shadow byte high, live byte low |

## Verification
Every output and status change is registered once. A stimulus sampled at one rising edge is therefore visible after that edge and is checked one full cycle after it is applied. The bench applies inputs at a falling edge and checks at the next falling edge. A non-maskable edge that loses to a reset is due two cycles after the reset take, because of the dead cycle that follows every take, and the bench checks it at exactly that cycle. Requests held off by the mask or by prefixBusy are checked for absence over two or more cycles before release, and then for the take one cycle after release.

// File: rtl/trapPkg.sv
package trapPkg;

  typedef enum logic [2:0] {
    CAUSE_NONE,
    CAUSE_RESET,
    CAUSE_NMI,
    CAUSE_WATCH,
    CAUSE_IRQ,
    CAUSE_SYS,
    CAUSE_BRK
  } causeT;

  // Strobes from control to the status datapath, mutually qualified by control
  typedef struct packed {
    logic enter;
    logic iret;
    logic setMask;
    logic clrMask;
    logic restoreMask;
    logic loadFlags;
  } flagStrobeT;

  // Distance of each entry address below the all-ones address
  localparam int OFS_RESET = 3;
  localparam int OFS_NMI   = 7;
  localparam int OFS_IRQ   = 11;
  localparam int OFS_WATCH = 15;
  localparam int OFS_SYS   = 59;
  localparam int OFS_BRK   = 63;

endpackage

// File: rtl/trapCtrl.sv
module trapCtrl
  import trapPkg::*;
#(
  parameter int PC_W = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            hwResetReq,
  input  logic            nmiReq,
  input  logic            watchReq,
  input  logic            irqReq,
  input  logic            prefixBusy,
  input  logic            swResetOp,
  input  logic            swNmiOp,
  input  logic            swIrqOp,
  input  logic            sysOp,
  input  logic            brkOp,
  input  logic            diOp,
  input  logic            eiOp,
  input  logic            riOp,
  input  logic            iretOp,
  input  logic            stopOp,
  input  logic            go,
  input  logic            flagUpd,
  input  logic [PC_W-1:0] curPc,
  input  logic            maskBit,
  output flagStrobeT      strobes,
  output logic            takeTrap,
  output logic [PC_W-1:0] trapVector,
  output logic            saveRet,
  output logic [PC_W-1:0] retAddr,
  output logic            pcRestore,
  output logic            stalled
);

  localparam logic [PC_W-1:0] ALL_ONES  = '1;
  localparam logic [PC_W-1:0] VEC_RESET = ALL_ONES - PC_W'(OFS_RESET);
  localparam logic [PC_W-1:0] VEC_NMI   = ALL_ONES - PC_W'(OFS_NMI);
  localparam logic [PC_W-1:0] VEC_IRQ   = ALL_ONES - PC_W'(OFS_IRQ);
  localparam logic [PC_W-1:0] VEC_WATCH = ALL_ONES - PC_W'(OFS_WATCH);
  localparam logic [PC_W-1:0] VEC_SYS   = ALL_ONES - PC_W'(OFS_SYS);
  localparam logic [PC_W-1:0] VEC_BRK   = ALL_ONES - PC_W'(OFS_BRK);

  logic resetPrev, nmiPrev, resetPend, nmiPend;
  logic resetNow, nmiNow, enter, hwOpen;
  causeT cause;
  logic [PC_W-1:0] vecSel;

  assign resetNow = resetPend | (hwResetReq & ~resetPrev);
  assign nmiNow   = nmiPend   | (nmiReq & ~nmiPrev);
  assign hwOpen   = ~prefixBusy;

  // Fixed-priority selection; nothing is accepted in the cycle after a take
  always_comb begin
    cause = CAUSE_NONE;
    if (!takeTrap) begin
      if (resetNow || swResetOp)                              cause = CAUSE_RESET;
      else if ((nmiNow && hwOpen) || swNmiOp)                 cause = CAUSE_NMI;
      else if (watchReq && hwOpen)                            cause = CAUSE_WATCH;
      else if (((irqReq && hwOpen) || swIrqOp) && !maskBit)   cause = CAUSE_IRQ;
      else if (sysOp)                                         cause = CAUSE_SYS;
      else if (brkOp)                                         cause = CAUSE_BRK;
    end
  end

  assign enter = (cause != CAUSE_NONE);

  always_comb begin
    case (cause)
      CAUSE_RESET: vecSel = VEC_RESET;
      CAUSE_NMI:   vecSel = VEC_NMI;
      CAUSE_WATCH: vecSel = VEC_WATCH;
      CAUSE_IRQ:   vecSel = VEC_IRQ;
      CAUSE_SYS:   vecSel = VEC_SYS;
      CAUSE_BRK:   vecSel = VEC_BRK;
      default:     vecSel = '0;
    endcase
  end

  // A taken trap displaces the instruction of this cycle
  always_comb begin
    strobes.enter       = enter;
    strobes.iret        = !enter && iretOp;
    strobes.setMask     = !enter && diOp;
    strobes.clrMask     = !enter && eiOp;
    strobes.restoreMask = !enter && riOp;
    strobes.loadFlags   = !enter && flagUpd;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resetPrev  <= 1'b0;
      nmiPrev    <= 1'b0;
      resetPend  <= 1'b0;
      nmiPend    <= 1'b0;
      takeTrap   <= 1'b0;
      trapVector <= '0;
      saveRet    <= 1'b0;
      retAddr    <= '0;
      pcRestore  <= 1'b0;
      stalled    <= 1'b0;
    end else begin
      resetPrev <= hwResetReq;
      nmiPrev   <= nmiReq;
      resetPend <= resetNow && (cause != CAUSE_RESET);
      nmiPend   <= nmiNow && (cause != CAUSE_NMI);
      takeTrap  <= enter;
      saveRet   <= enter && !(cause == CAUSE_RESET && resetNow);
      pcRestore <= strobes.iret;
      if (enter) begin
        trapVector <= vecSel;
        retAddr    <= curPc;
      end
      if (enter)        stalled <= 1'b0;
      else if (stalled) stalled <= !go;
      else              stalled <= stopOp;
    end
  end

endmodule

// File: rtl/flagPath.sv
module flagPath
  import trapPkg::*;
#(
  parameter int HALF_W   = 8,
  parameter int FLAG_N   = 4,
  parameter int MASK_POS = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  flagStrobeT          strobes,
  input  logic [FLAG_N-1:0]   flagNew,
  output logic                maskBit,
  output logic [2*HALF_W-1:0] statusOut
);

  localparam logic [HALF_W-1:0] LIVE_INIT = HALF_W'(1) << MASK_POS;

  logic [HALF_W-1:0] live, shadow, liveNext, shadowNext;

  always_comb begin
    liveNext   = live;
    shadowNext = shadow;
    if (strobes.enter) begin
      shadowNext         = live;
      liveNext[MASK_POS] = 1'b1;
    end else if (strobes.iret) begin
      liveNext = shadow;
    end else begin
      if (strobes.loadFlags)        liveNext[FLAG_N-1:0] = flagNew;
      if (strobes.setMask)          liveNext[MASK_POS]   = 1'b1;
      else if (strobes.clrMask)     liveNext[MASK_POS]   = 1'b0;
      else if (strobes.restoreMask) liveNext[MASK_POS]   = shadow[MASK_POS];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      live   <= LIVE_INIT;
      shadow <= '0;
    end else begin
      live   <= liveNext;
      shadow <= shadowNext;
    end
  end

  assign maskBit   = live[MASK_POS];
  assign statusOut = {shadow, live};

endmodule

// File: rtl/trapFlagUnit.sv
module trapFlagUnit
  import trapPkg::*;
#(
  parameter int PC_W     = 16,
  parameter int HALF_W   = 8,
  parameter int FLAG_N   = 4,
  parameter int MASK_POS = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                hwResetReq,
  input  logic                nmiReq,
  input  logic                watchReq,
  input  logic                irqReq,
  input  logic                prefixBusy,
  input  logic                swResetOp,
  input  logic                swNmiOp,
  input  logic                swIrqOp,
  input  logic                sysOp,
  input  logic                brkOp,
  input  logic                diOp,
  input  logic                eiOp,
  input  logic                riOp,
  input  logic                iretOp,
  input  logic                stopOp,
  input  logic                go,
  input  logic                flagUpd,
  input  logic [FLAG_N-1:0]   flagNew,
  input  logic [PC_W-1:0]     curPc,
  output logic                takeTrap,
  output logic [PC_W-1:0]     trapVector,
  output logic                saveRet,
  output logic [PC_W-1:0]     retAddr,
  output logic                pcRestore,
  output logic                stalled,
  output logic [2*HALF_W-1:0] statusOut
);

  flagStrobeT strobes;
  logic       maskBit;

  trapCtrl #(.PC_W(PC_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .hwResetReq(hwResetReq), .nmiReq(nmiReq), .watchReq(watchReq), .irqReq(irqReq),
    .prefixBusy(prefixBusy),
    .swResetOp(swResetOp), .swNmiOp(swNmiOp), .swIrqOp(swIrqOp),
    .sysOp(sysOp), .brkOp(brkOp),
    .diOp(diOp), .eiOp(eiOp), .riOp(riOp), .iretOp(iretOp),
    .stopOp(stopOp), .go(go), .flagUpd(flagUpd),
    .curPc(curPc), .maskBit(maskBit), .strobes(strobes),
    .takeTrap(takeTrap), .trapVector(trapVector), .saveRet(saveRet),
    .retAddr(retAddr), .pcRestore(pcRestore), .stalled(stalled)
  );

  flagPath #(.HALF_W(HALF_W), .FLAG_N(FLAG_N), .MASK_POS(MASK_POS)) u_path (
    .clk(clk), .rstN(rstN), .strobes(strobes), .flagNew(flagNew),
    .maskBit(maskBit), .statusOut(statusOut)
  );

endmodule

// File: rtl/trapFlagChecker.sv
module trapFlagChecker
  import trapPkg::*;
#(
  parameter int PC_W     = 16,
  parameter int HALF_W   = 8,
  parameter int MASK_POS = 4
) (
  input logic                clk,
  input logic                rstN,
  input logic                prefixBusy,
  input logic                go,
  input logic                takeTrap,
  input logic [PC_W-1:0]     trapVector,
  input logic                pcRestore,
  input logic                stalled,
  input logic [2*HALF_W-1:0] statusOut
);

  localparam int SR_W = 2 * HALF_W;
  localparam logic [PC_W-1:0] ALL_ONES  = '1;
  localparam logic [PC_W-1:0] VEC_IRQ   = ALL_ONES - PC_W'(OFS_IRQ);
  localparam logic [PC_W-1:0] VEC_WATCH = ALL_ONES - PC_W'(OFS_WATCH);

  AST_TAKE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    takeTrap |=> !takeTrap); // R7

  AST_ENTRY_MASK: assert property (@(posedge clk) disable iff (!rstN)
    takeTrap |-> statusOut[MASK_POS]); // R2

  AST_ENTRY_SHADOW: assert property (@(posedge clk) disable iff (!rstN)
    takeTrap |-> statusOut[SR_W-1:HALF_W] == $past(statusOut[HALF_W-1:0])); // R2

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    (takeTrap && trapVector == VEC_IRQ) |-> !$past(statusOut[MASK_POS])); // R5

  AST_PREFIX_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (takeTrap && trapVector == VEC_WATCH) |-> !$past(prefixBusy)); // R6

  AST_IRET_COPY: assert property (@(posedge clk) disable iff (!rstN)
    pcRestore |-> statusOut[HALF_W-1:0] == $past(statusOut[SR_W-1:HALF_W])); // R10

  AST_GO_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (stalled && go) |=> !stalled); // R13

endmodule

bind trapFlagUnit trapFlagChecker #(.PC_W(PC_W), .HALF_W(HALF_W), .MASK_POS(MASK_POS)) u_trapChk (
  .clk(clk), .rstN(rstN), .prefixBusy(prefixBusy), .go(go),
  .takeTrap(takeTrap), .trapVector(trapVector), .pcRestore(pcRestore),
  .stalled(stalled), .statusOut(statusOut)
);

// File: tb/test_trapFlagUnit.sv
`timescale 1ns/1ps
module test_trapFlagUnit;

  logic clk = 1'b0;
  logic rstN;
  logic hwResetReq, nmiReq, watchReq, irqReq, prefixBusy;
  logic swResetOp, swNmiOp, swIrqOp, sysOp, brkOp;
  logic diOp, eiOp, riOp, iretOp, stopOp, go, flagUpd;
  logic [3:0]  flagNew;
  logic [15:0] curPc;
  logic        takeTrap, saveRet, pcRestore, stalled;
  logic [15:0] trapVector, retAddr, statusOut;

  int nChecks = 0;
  int nErrors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  trapFlagUnit i_trapFlagUnit (
    .clk(clk), .rstN(rstN),
    .hwResetReq(hwResetReq), .nmiReq(nmiReq), .watchReq(watchReq), .irqReq(irqReq),
    .prefixBusy(prefixBusy),
    .swResetOp(swResetOp), .swNmiOp(swNmiOp), .swIrqOp(swIrqOp),
    .sysOp(sysOp), .brkOp(brkOp),
    .diOp(diOp), .eiOp(eiOp), .riOp(riOp), .iretOp(iretOp),
    .stopOp(stopOp), .go(go), .flagUpd(flagUpd), .flagNew(flagNew), .curPc(curPc),
    .takeTrap(takeTrap), .trapVector(trapVector), .saveRet(saveRet),
    .retAddr(retAddr), .pcRestore(pcRestore), .stalled(stalled), .statusOut(statusOut)
  );

  task automatic idle();
    hwResetReq = 0; nmiReq = 0; watchReq = 0; irqReq = 0; prefixBusy = 0;
    swResetOp = 0; swNmiOp = 0; swIrqOp = 0; sysOp = 0; brkOp = 0;
    diOp = 0; eiOp = 0; riOp = 0; iretOp = 0; stopOp = 0; go = 0;
    flagUpd = 0; flagNew = 4'h0;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Live byte = flags with mask clear
  task automatic prime(input logic [3:0] f);
    idle(); eiOp = 1; flagUpd = 1; flagNew = f; step(); idle(); step();
  endtask

  function automatic logic [15:0] vecOf(input int k);
    case (k)
      0, 1: return 16'hFFFC;
      2, 3: return 16'hFFF8;
      4:    return 16'hFFF0;
      5, 6: return 16'hFFF4;
      7:    return 16'hFFC4;
      default: return 16'hFFC0;
    endcase
  endfunction

  initial begin
    #(4 * 200000);
    if (!finished) begin
      nChecks++; nErrors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
      $finish;
    end
  end

  initial begin
    idle(); curPc = 16'h0100; rstN = 0;
    repeat (3) step();
    rstN = 1; step();
    chk(statusOut, 16'h0010, "R1 status after reset");
    chk({takeTrap, saveRet, pcRestore, stalled}, 0, "R1 strobes after reset");

    flagUpd = 1; flagNew = 4'hA; step(); idle();
    chk(statusOut, 16'h001A, "R11 flag load keeps mask");
    eiOp = 1; step(); idle();
    chk(statusOut, 16'h000A, "R8 mask clear");
    diOp = 1; step(); idle();
    chk(statusOut, 16'h001A, "R8 mask set");
    eiOp = 1; step(); idle();
    chk(statusOut, 16'h000A, "R8 mask clear again");

    // Every cause alone
    for (int k = 0; k < 9; k++) begin
      prime(4'hA);
      curPc = 16'h1200 + 16'(k);
      case (k)
        0: hwResetReq = 1; 1: swResetOp = 1; 2: nmiReq = 1; 3: swNmiOp = 1;
        4: watchReq = 1;   5: irqReq = 1;    6: swIrqOp = 1; 7: sysOp = 1;
        default: brkOp = 1;
      endcase
      step(); idle();
      chk(takeTrap, 1, "R2 take");
      chk(trapVector, vecOf(k), "R3 vector");
      chk(retAddr, 16'h1200 + 16'(k), "R2 return address");
      chk(saveRet, (k != 0), "R3 save strobe");
      chk(statusOut, 16'h0A1A, "R2 shadow copy and mask");
      step();
      chk(takeTrap, 0, "R7 single-cycle take");
    end

    // All coincidences of reset, nmi, watch, irq, sys, brk
    for (int m = 1; m < 64; m++) begin
      logic [15:0] ev;
      prime(4'h0);
      hwResetReq = m[5]; nmiReq = m[4]; watchReq = m[3];
      irqReq = m[2]; sysOp = m[1]; brkOp = m[0];
      if (m[5])      ev = 16'hFFFC;
      else if (m[4]) ev = 16'hFFF8;
      else if (m[3]) ev = 16'hFFF0;
      else if (m[2]) ev = 16'hFFF4;
      else if (m[1]) ev = 16'hFFC4;
      else           ev = 16'hFFC0;
      step(); idle();
      chk(trapVector, ev, "R4 priority");
      step();
      chk(takeTrap, 0, "R7 dead cycle after take");
      step();
      chk(takeTrap, (m[5] && m[4]), "R7 pending nmi after reset");
      if (m[5] && m[4]) chk(trapVector, 16'hFFF8, "R7 pending nmi vector");
    end

    // Mask
    idle(); step(); diOp = 1; step(); idle();
    irqReq = 1; step();
    chk(takeTrap, 0, "R5 external irq masked");
    step();
    chk(takeTrap, 0, "R5 held irq masked");
    irqReq = 0; swIrqOp = 1; step(); idle();
    chk(takeTrap, 0, "R5 software irq masked");
    nmiReq = 1; step(); idle();
    chk(takeTrap, 1, "R5 nmi unmasked");
    chk(trapVector, 16'hFFF8, "R5 nmi vector");
    step(); step();
    eiOp = 1; irqReq = 1; step(); eiOp = 0;
    chk(takeTrap, 0, "R5 irq sampled with old mask");
    step(); idle();
    chk(takeTrap, 1, "R5 irq after unmask");
    chk(trapVector, 16'hFFF4, "R5 irq vector");
    step();

    // Prefix hold-off
    prime(4'h0);
    prefixBusy = 1; nmiReq = 1; watchReq = 1; irqReq = 1; step();
    chk(takeTrap, 0, "R6 held by prefix");
    step();
    chk(takeTrap, 0, "R6 still held by prefix");
    idle(); step();
    chk(takeTrap, 1, "R6 pending nmi after prefix");
    chk(trapVector, 16'hFFF8, "R6 pending nmi vector");
    step();
    chk(takeTrap, 0, "R6 no further take");
    prefixBusy = 1; hwResetReq = 1; step(); idle();
    chk(takeTrap, 1, "R6 reset passes prefix");
    chk(saveRet, 0, "R3 no save on external reset");
    step();
    prefixBusy = 1; sysOp = 1; step(); idle();
    chk(trapVector, 16'hFFC4, "R6 system call passes prefix");
    step();

    // Mask restore
    prime(4'h0);
    sysOp = 1; step(); idle();
    chk(statusOut, 16'h0010, "R2 entry from clear mask");
    flagUpd = 1; flagNew = 4'h5; step(); idle();
    chk(statusOut, 16'h0015, "R11 flags after entry");
    riOp = 1; step(); idle();
    chk(statusOut, 16'h0005, "R9 restore clear mask only");
    diOp = 1; step(); idle();
    brkOp = 1; step(); idle();
    chk(statusOut, 16'h1515, "R2 entry from set mask");
    step();
    eiOp = 1; flagUpd = 1; flagNew = 4'h3; step(); idle();
    chk(statusOut, 16'h1503, "R8 clear with flag load");
    riOp = 1; step(); idle();
    chk(statusOut, 16'h1513, "R9 restore set mask only");

    // Return
    flagUpd = 1; flagNew = 4'h0; step(); idle();
    chk(statusOut, 16'h1510, "R11 flags cleared");
    iretOp = 1; step(); idle();
    chk(statusOut, 16'h1515, "R10 shadow to live");
    chk(pcRestore, 1, "R10 restore strobe");
    step();
    chk(pcRestore, 0, "R10 restore strobe one cycle");

    // Displaced instruction
    prime(4'h6);
    watchReq = 1; flagUpd = 1; flagNew = 4'hF; stopOp = 1; iretOp = 1; eiOp = 1;
    step(); idle();
    chk(takeTrap, 1, "R12 trap taken");
    chk(statusOut, 16'h0616, "R12 strobes ignored on take");
    chk({stalled, pcRestore}, 0, "R12 stop and return ignored");
    step();

    // Stop and go
    stopOp = 1; step(); idle();
    chk(stalled, 1, "R13 stall begins");
    step();
    chk(stalled, 1, "R13 stall holds");
    step();
    chk(stalled, 1, "R13 stall holds without go");
    go = 1; step();
    chk(stalled, 0, "R13 go releases");
    chk(takeTrap, 0, "R13 go causes no take");
    go = 0; step();
    chk(stalled, 0, "R13 stays released");
    stopOp = 1; step(); idle();
    chk(stalled, 1, "R13 stall again");
    watchReq = 1; step(); idle();
    chk(takeTrap, 1, "R13 trap while stalled");
    chk(stalled, 0, "R13 trap releases stall");
    step();

    finished = 1;
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

endmodule